// File: doc/BRIEF.md
# Dual-Channel Digital Multiplying Attenuator

This block is a clocked digital model of a two-channel multiplying converter. Channels A and B each keep an 8-bit code. Both codes are loaded through one shared write port. The port has an active-low chip-select, an active-low write strobe and a channel-select line. Each channel multiplies its own signed 16-bit reference sample stream by its stored code. It then emits a scaled 16-bit product on every clock.

A mode input picks the scaling. In unipolar mode the result is the reference times the code over 256, with the sign inverted. In bipolar mode the code is offset binary, and the result is the reference times (code/128 - 1). All write-port lines, including the data bus, pass through two-flop synchronizers. While the selected channel's strobes are both low, its register follows the bus. When either strobe rises, the register freezes. A sticky flag reports any write whose data was not stable long enough before or after the strobe rise.

Top module: `dual_mult_atten`

## Requirements
- R1: After reset both outputs read 0 in unipolar mode and `timing_err` is 0.
- R2: With `cs_n` = 0, `wr_n` = 0 and `chan_sel` = 0, channel A's code follows `wr_data`. A bus change shows on `out_a` at the fourth rising clock edge after it is driven, and not at the third.
- R3: With both strobes low and `chan_sel` = 1, the write goes to channel B.
- R4: Once `cs_n` or `wr_n` is high, later changes on `wr_data` leave both stored codes unchanged. Each register keeps the last value it saw while write mode was active.
- R5: A write to one channel never changes the other channel's output.
- R6: With `bipolar` = 0, the output is -trunc(ref*D/256), where D is the unsigned code (bit 0 is the LSB). Truncation is toward zero. Code 0 gives 0.
- R7: With `bipolar` = 1, the output is trunc(ref*(D-128)/128), truncated toward zero. Code 128 gives 0.
- R8: In bipolar mode, code 0 with ref = -32768 saturates the output to +32767.
- R9: A change on a reference input or on `bipolar` shows on the output exactly one clock later.
- R10: A strobe rise that comes fewer than SETUP_CYC synchronized cycles after the last data change sets `timing_err`. The flag then stays set until reset.
- R11: A data change in the strobe-rise cycle, or within HOLD_CYC cycles after it, sets `timing_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| chan_sel | input | 1 | 0 writes channel A, 1 writes channel B |
| wr_data | input | 8 | Shared code bus |
| bipolar | input | 1 | 0 selects unipolar scaling, 1 selects bipolar scaling |
| ref_a | input | 16 | Channel A reference sample, two's complement |
| ref_b | input | 16 | Channel B reference sample, two's complement |
| out_a | output | 16 | Channel A scaled product, two's complement |
| out_b | output | 16 | Channel B scaled product, two's complement |
| timing_err | output | 1 | Sticky setup/hold violation flag |

## Verification
The port assertions assume that `chan_sel` and `wr_data` reach the synchronizers together with the strobes. They also assume that the strobe lines do not glitch faster than the clock. The stimulus meets this by changing the write-port lines only on falling clock edges. Ordinary writes hold data for eight cycles before the strobe rise and for six cycles after it. Only the two directed violation cases break those windows. The scaling assertions assume `bipolar` and the references are steady across the edge being checked, so the bench changes them only between checks.

// File: rtl/mda_pkg.sv
package mda_pkg;
  typedef enum logic { CH_A = 1'b0, CH_B = 1'b1 } chan_e;
  typedef enum logic { MODE_UNI = 1'b0, MODE_BI = 1'b1 } mode_e;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/mda_sync.sv
module mda_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/mda_port.sv
module mda_port #(
  parameter int CW        = 8,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 2,
  parameter int NCH       = mda_pkg::NUM_CH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    wr_n,
  input  logic                    chan_sel,
  input  logic [CW-1:0]           wr_data,
  output logic [NCH-1:0][CW-1:0]  code,
  output logic                    timing_err
);
  localparam int SW = $clog2(SETUP_CYC + 1) + 1;
  localparam int HW = $clog2(HOLD_CYC + 1) + 1;
  localparam int BW = CW + 3;
  localparam logic [BW-1:0] SYNC_RST = {2'b11, {(CW + 1){1'b0}}};

  logic [BW-1:0] sync_q;
  logic          cs_s, wr_s, sel_s;
  logic [CW-1:0] data_s;

  mda_sync #(.W(BW), .RST(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, wr_n, chan_sel, wr_data}),
    .q     (sync_q)
  );
  assign {cs_s, wr_s, sel_s, data_s} = sync_q;

  logic          active, active_q;
  logic [CW-1:0] data_q;
  logic [SW-1:0] stable_q, stable_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          err_q, err_d;
  logic          chg, rise;

  assign active = !cs_s && !wr_s;
  assign chg    = (data_s != data_q);
  assign rise   = active_q && !active;

  always_comb begin
    if (chg)
      stable_d = '0;
    else if (stable_q >= SW'(SETUP_CYC))
      stable_d = stable_q;
    else
      stable_d = stable_q + 1'b1;

    if (rise)
      hold_d = HW'(HOLD_CYC);
    else if (hold_q != '0)
      hold_d = hold_q - 1'b1;
    else
      hold_d = '0;

    err_d = err_q
          | (rise && ((stable_q < SW'(SETUP_CYC)) || chg))
          | ((hold_q != '0) && chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      data_q   <= '0;
      stable_q <= '0;
      hold_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active;
      data_q   <= data_s;
      stable_q <= stable_d;
      hold_q   <= hold_d;
      err_q    <= err_d;
    end
  end

  logic [NCH-1:0][CW-1:0] code_q;
  logic [NCH-1:0]         load_en;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign load_en[g] = active && (32'(sel_s) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[g] <= '0;
      else if (load_en[g])
        code_q[g] <= data_s;
    end
  end

  assign code       = code_q;
  assign timing_err = err_q;

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s || wr_s) |=> $stable(code_q));

  p_one_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(code_q[0]) && !$stable(code_q[1])));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  p_late_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && chg) |=> err_q);
endmodule

// File: rtl/mda_scale.sv
module mda_scale #(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bipolar,
  input  logic [CW-1:0] code,
  input  logic [DW-1:0] ref_in,
  output logic [DW-1:0] out_q
);
  localparam int PW = DW + CW + 2;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (CW - 1);
  localparam logic signed [PW-1:0] FULL = PW'(1) <<< CW;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW - 1));

  logic signed [PW-1:0] refx, cu, mult, prod, bias, biased, shifted, res;
  logic [DW-1:0]        out_d;

  always_comb begin
    refx    = PW'($signed(ref_in));
    cu      = $signed({{(PW - CW){1'b0}}, code});
    mult    = bipolar ? (cu - HALF) : cu;
    prod    = refx * mult;
    bias    = bipolar ? (HALF - PW'(1)) : (FULL - PW'(1));
    biased  = (prod < 0) ? (prod + bias) : prod;
    shifted = bipolar ? (biased >>> (CW - 1)) : (biased >>> CW);
    res     = bipolar ? shifted : -shifted;
    if (res > MAXV)
      out_d = MAXV[DW-1:0];
    else if (res < MINV)
      out_d = MINV[DW-1:0];
    else
      out_d = res[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= '0;
    else
      out_q <= out_d;
  end

  p_uni_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bipolar && code == '0) |=> (out_q == '0));

  p_uni_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bipolar && !ref_in[DW-1]) |=> (out_q == '0 || out_q[DW-1]));

  p_mid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bipolar && code == CW'(1 << (CW - 1))) |=> (out_q == '0));

  p_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bipolar && code == '0 && ref_in == MINV[DW-1:0]) |=> (out_q == MAXV[DW-1:0]));
endmodule

// File: rtl/dual_mult_atten.sv
module dual_mult_atten #(
  parameter int DW        = 16,
  parameter int CW        = 8,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          chan_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          bipolar,
  input  logic [DW-1:0] ref_a,
  input  logic [DW-1:0] ref_b,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_b,
  output logic          timing_err
);
  localparam int NCH = mda_pkg::NUM_CH;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NCH-1:0][CW-1:0] code;
  logic [NCH-1:0][DW-1:0] refs, outs;

  mda_port #(.CW(CW), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .NCH(NCH)) u_port (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_n       (cs_n),
    .wr_n       (wr_n),
    .chan_sel   (chan_sel),
    .wr_data    (wr_data),
    .code       (code),
    .timing_err (timing_err)
  );

  assign refs = {ref_b, ref_a};

  for (genvar g = 0; g < NCH; g++) begin : g_scale
    mda_scale #(.DW(DW), .CW(CW)) u_scale (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .bipolar (bipolar),
      .code    (code[g]),
      .ref_in  (refs[g]),
      .out_q   (outs[g])
    );
  end

  assign out_a = outs[mda_pkg::CH_A];
  assign out_b = outs[mda_pkg::CH_B];
endmodule

// File: tb/dual_mult_atten_bench.sv
module dual_mult_atten_bench;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_n, chan_sel, bipolar;
  logic [7:0]  wr_data;
  logic [15:0] ref_a, ref_b, out_a, out_b;
  logic        timing_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dual_mult_atten u_dual_mult_atten (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .chan_sel(chan_sel),
    .wr_data(wr_data), .bipolar(bipolar), .ref_a(ref_a), .ref_b(ref_b),
    .out_a(out_a), .out_b(out_b), .timing_err(timing_err)
  );

  // {bipolar, code, ref, expected}
  localparam logic [40:0] VEC [0:12] = '{
    {1'b0, 8'd0,   16'h03E8, 16'h0000},
    {1'b0, 8'd255, 16'h7FFF, 16'h8081},
    {1'b0, 8'd128, 16'hFC18, 16'h01F4},
    {1'b0, 8'd1,   16'h00FF, 16'h0000},
    {1'b0, 8'd1,   16'hFF00, 16'h0001},
    {1'b0, 8'd255, 16'h8000, 16'h7F80},
    {1'b1, 8'd128, 16'h3039, 16'h0000},
    {1'b1, 8'd0,   16'h03E8, 16'hFC18},
    {1'b1, 8'd255, 16'h0500, 16'h04F6},
    {1'b1, 8'd0,   16'h8000, 16'h7FFF},
    {1'b1, 8'd129, 16'h007F, 16'h0000},
    {1'b1, 8'd127, 16'h007F, 16'h0000},
    {1'b1, 8'd255, 16'h8000, 16'h8100}
  };

  function automatic int model(bit bip, int d, int r);
    int q;
    if (!bip) return -((r * d) / 256);
    q = (r * (d - 128)) / 128;
    if (q > 32767) q = 32767;
    return q;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_code(bit ch, logic [7:0] d);
    @(negedge clk);
    chan_sel = ch; wr_data = d; cs_n = 1'b0; wr_n = 1'b0;
    cyc(8);
    cs_n = 1'b1; wr_n = 1'b1;
    cyc(6);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b1; wr_n = 1'b1; chan_sel = 1'b0; wr_data = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : main
    bipolar = 1'b0; ref_a = 16'd1000; ref_b = 16'hF000;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; chan_sel = 1'b0; wr_data = 8'h00;
    do_reset();

    // R1 reset state
    chk("R1 out_a", $signed(out_a), 0);
    chk("R1 out_b", $signed(out_b), 0);
    chk("R1 timing_err", timing_err, 0);

    // R2 transparency and port latency; R9 reference latency
    @(negedge clk);
    chan_sel = 1'b0; wr_data = 8'h40; cs_n = 1'b0; wr_n = 1'b0;
    cyc(3);
    chk("R2 no change at third edge", $signed(out_a), 0);
    cyc(1);
    chk("R2 change at fourth edge", $signed(out_a), model(0, 64, 1000));
    wr_data = 8'h80;
    cyc(8);
    chk("R2 follows bus while written", $signed(out_a), model(0, 128, 1000));
    cs_n = 1'b1; wr_n = 1'b1;
    cyc(6);
    // R4 bus ignored after strobe rise
    wr_data = 8'h11;
    cyc(8);
    chk("R4 hold after rise", $signed(out_a), model(0, 128, 1000));
    chk("R4 B untouched", $signed(out_b), 0);
    ref_a = 16'd2000;
    cyc(1);
    chk("R9 ref latency one clock", $signed(out_a), model(0, 128, 2000));
    bipolar = 1'b1;
    cyc(1);
    chk("R9 mode latency one clock", $signed(out_a), model(1, 128, 2000));
    bipolar = 1'b0;

    // R3 / R5 write B, A unchanged
    write_code(1'b1, 8'd200);
    cyc(1);
    chk("R3 B written", $signed(out_b), model(0, 200, -4096));
    chk("R5 A unchanged by B write", $signed(out_a), model(0, 128, 2000));
    write_code(1'b0, 8'd7);
    cyc(1);
    chk("R5 B unchanged by A write", $signed(out_b), model(0, 200, -4096));

    // R6 R7 R8 corner vectors on channel A
    foreach (VEC[i]) begin
      bipolar = VEC[i][40];
      ref_a   = VEC[i][31:16];
      write_code(1'b0, VEC[i][39:32]);
      cyc(1);
      if (VEC[i][40] && VEC[i][39:32] == 8'd0 && VEC[i][31:16] == 16'h8000)
        chk("R8 saturation", $signed(out_a), $signed(VEC[i][15:0]));
      else if (VEC[i][40])
        chk("R7 bipolar vector", $signed(out_a), $signed(VEC[i][15:0]));
      else
        chk("R6 unipolar vector", $signed(out_a), $signed(VEC[i][15:0]));
    end

    // R6 R7 every code, both modes, both polarities
    for (int c = 0; c < 256; c++) begin
      write_code(1'b0, 8'(c));
      write_code(1'b1, 8'(255 - c));
      for (int m = 0; m < 2; m++) begin
        for (int p = 0; p < 2; p++) begin
          @(negedge clk);
          bipolar = m[0];
          ref_a = p ? 16'hA45F : 16'd31111;
          ref_b = p ? 16'h8000 : 16'd20000;
          cyc(2);
          chk(m ? "R7 sweep A" : "R6 sweep A", $signed(out_a),
              model(m[0], c, $signed(ref_a)));
          chk(m ? "R7 sweep B" : "R6 sweep B", $signed(out_b),
              model(m[0], 255 - c, $signed(ref_b)));
        end
      end
    end
    chk("R10 no flag on clean writes", timing_err, 0);

    // R10 setup violation
    bipolar = 1'b0;
    do_reset();
    @(negedge clk);
    chan_sel = 1'b0; wr_data = 8'h21; cs_n = 1'b0; wr_n = 1'b0;
    cyc(8);
    wr_data = 8'h22;
    cyc(1);
    wr_n = 1'b1; cs_n = 1'b1;
    cyc(8);
    chk("R10 setup violation flagged", timing_err, 1);
    cyc(10);
    chk("R10 flag sticky", timing_err, 1);

    // R11 hold violation
    do_reset();
    chk("R11 flag cleared by reset", timing_err, 0);
    @(negedge clk);
    chan_sel = 1'b1; wr_data = 8'h33; cs_n = 1'b0; wr_n = 1'b0;
    cyc(8);
    wr_n = 1'b1; wr_data = 8'h34;
    cyc(8);
    chk("R11 hold violation flagged", timing_err, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule